// File: doc/BRIEF.md
# Interrupt Source Bank with Redelivery

This block keeps the state of a bank of interrupt sources and turns their events into delivery requests for downstream presentation logic. For each source it stores a target server, a live priority, a saved priority and four flags: level-sensitive, asserted, needs-resend and held-while-masked. Source events (level changes), configuration commands (set target and priority, enable, disable) and end-of-interrupt notices all come in as plain strobes. Each of them may cause a delivery attempt.

An attempt on a masked source is not lost. It leaves a held mark, and the source is delivered when it is later unmasked. A presentation controller that cannot take a request reports a refusal. The source then gets a resend flag, and the bank answers with a one-cycle notice carrying its own controller number, which the presenter can record. A resend command walks the sources in ascending index and retries every flagged one. A level-sensitive source that is still asserted at end-of-interrupt is delivered again.

Requests leave one at a time on a valid/ready stream carrying the source number, priority and server. A request stays valid with all fields stable until ready is seen high at a clock edge. While the stream is stalled the resend walk holds its position and no new request is loaded. When several sources are waiting, the lowest index goes first.

Top module: `isc_bank`

## Requirements
- R1: After reset, every source is unconfigured with live and saved priority 0xFF (masked), `dlv_valid`, `err_pulse` and `rsn_valid` are low.
- R2: A delivery attempt clears the source's resend flag; if the live priority is 0xFF no request is issued and the held mark is set instead.
- R3: A level event with value 1 sets asserted on a level-sensitive source and attempts delivery, on an edge source it attempts delivery; value 0 clears asserted and delivers nothing.
- R4: Set command (`cfg_op`=2'b00) stores server, live priority, saved priority and the level-sensitive flag and marks the source configured; if the held mark or resend flag was set and the new priority is not 0xFF, the held mark is cleared and delivery is attempted.
- R5: Disable (`cfg_op`=2'b10) copies live priority into saved priority and sets live priority to 0xFF; a request still waiting for the stream becomes a held mark.
- R6: Enable (`cfg_op`=2'b01) copies saved priority into live priority and applies the same held/resend delivery check as R4; code 2'b11 does nothing.
- R7: A refusal sets the source's resend flag, and one cycle later `rsn_valid` pulses with `rsn_ctrl` equal to the bank's controller number.
- R8: End-of-interrupt on a source whose asserted flag is set attempts delivery again; otherwise it delivers nothing.
- R9: A resend command visits indices 0 to NSRC-1 in order, one per unstalled cycle, attempting delivery on each flagged source; the walk does not advance while `dlv_valid` is high and `dlv_ready` low.
- R10: Level and end-of-interrupt events on an unconfigured source change nothing and cause a one-cycle `err_pulse` in the following cycle.
- R11: While `dlv_valid` is high and `dlv_ready` low, `dlv_valid` stays high and `dlv_src`, `dlv_prio`, `dlv_server` stay unchanged.
- R12: `dlv_src` is the controller number (upper CTRL_W bits) concatenated with the local index (lower bits).
- R13: When several sources wait for the stream, the lowest local index is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_valid | input | 1 | Level event strobe |
| lvl_idx | input | IDX_W | Source index of level event |
| lvl_value | input | 1 | New level |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_op | input | 2 | 00 set, 01 enable, 10 disable, 11 none |
| cfg_idx | input | IDX_W | Source index of command |
| cfg_server | input | SRV_W | Target server for set |
| cfg_prio | input | PRIO_W | Priority for set |
| cfg_lsi | input | 1 | Level-sensitive flag for set |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_idx | input | IDX_W | Source index of end-of-interrupt |
| rej_valid | input | 1 | Refusal strobe from presenter |
| rej_idx | input | IDX_W | Refused source index |
| resend_req | input | 1 | Start a resend walk |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery request accepted |
| dlv_src | output | CTRL_W+IDX_W | Source number |
| dlv_prio | output | PRIO_W | Request priority |
| dlv_server | output | SRV_W | Target server |
| rsn_valid | output | 1 | Refusal notice pulse |
| rsn_ctrl | output | CTRL_W | Controller number for resend tracking |
| err_pulse | output | 1 | Event on unconfigured source |

## Verification
A scoreboard holds the request stream to an exact ordered list. Level patterns (rise, fall, rise with end-of-interrupt) separate level-sensitive asserted redelivery from edge behaviour. Mask/unmask sequences separate a held mark from a dropped event, and a set command with priority 0xFF shows that masking survives reconfiguration. Refusals on several sources, one masked, replayed under a stalled stream show ascending walk order and that the walk pauses. Events queued behind a stalled request show lowest-index-first arbitration.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {
    CFG_SET = 2'b00,
    CFG_ENA = 2'b01,
    CFG_DIS = 2'b10,
    CFG_NOP = 2'b11
  } cfg_op_e;
endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot #(
  parameter int PRIO_W = 8,
  parameter int SRV_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_hit,
  input  isc_pkg::cfg_op_e     cfg_op,
  input  logic [SRV_W-1:0]     cfg_server,
  input  logic [PRIO_W-1:0]    cfg_prio,
  input  logic                 cfg_lsi,
  input  logic                 lvl_hit,
  input  logic                 lvl_value,
  input  logic                 eoi_hit,
  input  logic                 rej_hit,
  input  logic                 scan_hit,
  input  logic                 launch,
  output logic                 configured,
  output logic                 want,
  output logic [PRIO_W-1:0]    prio,
  output logic [SRV_W-1:0]     server
);
  import isc_pkg::*;
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [PRIO_W-1:0] prio_q, prio_n, saved_q, saved_n;
  logic [SRV_W-1:0]  srv_q, srv_n;
  logic lsi_q, lsi_n, asrt_q, asrt_n, rsnd_q, rsnd_n;
  logic held_q, held_n, want_q, want_n, cfgd_q, cfgd_n;
  logic attempt, recheck;

  always_comb begin
    prio_n = prio_q; saved_n = saved_q; srv_n = srv_q;
    lsi_n = lsi_q; asrt_n = asrt_q; rsnd_n = rsnd_q;
    held_n = held_q; want_n = want_q; cfgd_n = cfgd_q;
    attempt = 1'b0; recheck = 1'b0;
    if (launch) want_n = 1'b0;
    if (cfg_hit) begin
      case (cfg_op)
        CFG_SET: begin
          srv_n = cfg_server; prio_n = cfg_prio; saved_n = cfg_prio;
          lsi_n = cfg_lsi; cfgd_n = 1'b1; recheck = 1'b1;
          if (!cfg_lsi) asrt_n = 1'b0;
        end
        CFG_ENA: if (cfgd_q) begin prio_n = saved_q; recheck = 1'b1; end
        CFG_DIS: if (cfgd_q) begin saved_n = prio_q; prio_n = MASKED; end
        default: ;
      endcase
    end
    if (prio_n == MASKED && want_n) begin want_n = 1'b0; held_n = 1'b1; end
    if (recheck && (held_n || rsnd_n) && prio_n != MASKED) begin
      held_n = 1'b0; attempt = 1'b1;
    end
    if (lvl_hit && cfgd_q) begin
      if (lvl_value) begin
        if (lsi_n) asrt_n = 1'b1;
        attempt = 1'b1;
      end else asrt_n = 1'b0;
    end
    if (eoi_hit && cfgd_q && asrt_n) attempt = 1'b1;
    if (rej_hit) rsnd_n = 1'b1;
    if (scan_hit && rsnd_n) attempt = 1'b1;
    if (attempt) begin
      rsnd_n = 1'b0;
      if (prio_n == MASKED) held_n = 1'b1;
      else want_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= MASKED; saved_q <= MASKED; srv_q <= '0;
      lsi_q <= 1'b0; asrt_q <= 1'b0; rsnd_q <= 1'b0;
      held_q <= 1'b0; want_q <= 1'b0; cfgd_q <= 1'b0;
    end else begin
      prio_q <= prio_n; saved_q <= saved_n; srv_q <= srv_n;
      lsi_q <= lsi_n; asrt_q <= asrt_n; rsnd_q <= rsnd_n;
      held_q <= held_n; want_q <= want_n; cfgd_q <= cfgd_n;
    end
  end

  assign configured = cfgd_q;
  assign want       = want_q;
  assign prio       = prio_q;
  assign server     = srv_q;

  // R2
  want_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    want_q |-> prio_q != MASKED);
  // R3
  edge_never_asserted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lsi_q |-> !asrt_q);
  // R10
  unconfigured_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgd_q |-> !want_q && !asrt_q);
endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = i[IW-1:0];
    end
    any   = |req;
    grant = '0;
    if (any) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/isc_bank.sv
module isc_bank #(
  parameter int              NSRC    = 16,
  parameter int              CTRL_W  = 4,
  parameter logic [CTRL_W-1:0] CTRL_ID = 4'h3,
  parameter int              PRIO_W  = 8,
  parameter int              SRV_W   = 4,
  localparam int             IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int             SRC_W   = CTRL_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_valid,
  input  logic [IDX_W-1:0]  lvl_idx,
  input  logic              lvl_value,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_op,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_lsi,
  input  logic              eoi_valid,
  input  logic [IDX_W-1:0]  eoi_idx,
  input  logic              rej_valid,
  input  logic [IDX_W-1:0]  rej_idx,
  input  logic              resend_req,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [SRC_W-1:0]  dlv_src,
  output logic [PRIO_W-1:0] dlv_prio,
  output logic [SRV_W-1:0]  dlv_server,
  output logic              rsn_valid,
  output logic [CTRL_W-1:0] rsn_ctrl,
  output logic              err_pulse
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSRC - 1);

  logic [NSRC-1:0]   cfgd_v, want_v, launch, grant;
  logic [PRIO_W-1:0] prio_a [NSRC];
  logic [SRV_W-1:0]  srv_a  [NSRC];
  logic [IDX_W-1:0]  pick_idx, scan_ptr;
  logic              pick_any, scan_act, stall, load;

  assign stall = dlv_valid && !dlv_ready;
  assign load  = !stall;
  assign launch = load ? grant : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    isc_src_slot #(.PRIO_W(PRIO_W), .SRV_W(SRV_W)) slot_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_hit    (cfg_valid && cfg_idx == IDX_W'(i)),
      .cfg_op     (isc_pkg::cfg_op_e'(cfg_op)),
      .cfg_server (cfg_server),
      .cfg_prio   (cfg_prio),
      .cfg_lsi    (cfg_lsi),
      .lvl_hit    (lvl_valid && lvl_idx == IDX_W'(i)),
      .lvl_value  (lvl_value),
      .eoi_hit    (eoi_valid && eoi_idx == IDX_W'(i)),
      .rej_hit    (rej_valid && rej_idx == IDX_W'(i)),
      .scan_hit   (scan_act && !stall && scan_ptr == IDX_W'(i)),
      .launch     (launch[i]),
      .configured (cfgd_v[i]),
      .want       (want_v[i]),
      .prio       (prio_a[i]),
      .server     (srv_a[i])
    );
  end

  isc_pick #(.N(NSRC)) pick_i (
    .req   (want_v),
    .grant (grant),
    .idx   (pick_idx),
    .any   (pick_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_act <= 1'b0;
      scan_ptr <= '0;
    end else if (!scan_act) begin
      if (resend_req) begin
        scan_act <= 1'b1;
        scan_ptr <= '0;
      end
    end else if (!stall) begin
      if (scan_ptr == LAST_IDX) scan_act <= 1'b0;
      else scan_ptr <= scan_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_valid  <= 1'b0;
      dlv_src    <= '0;
      dlv_prio   <= '0;
      dlv_server <= '0;
    end else if (load) begin
      dlv_valid <= pick_any;
      if (pick_any) begin
        dlv_src    <= {CTRL_ID, pick_idx};
        dlv_prio   <= prio_a[pick_idx];
        dlv_server <= srv_a[pick_idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsn_valid <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      rsn_valid <= rej_valid;
      err_pulse <= (lvl_valid && !cfgd_v[lvl_idx]) || (eoi_valid && !cfgd_v[eoi_idx]);
    end
  end
  assign rsn_ctrl = CTRL_ID;

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_src) && $stable(dlv_prio) && $stable(dlv_server));
  // R9
  scan_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_act && dlv_valid && !dlv_ready |=> $stable(scan_ptr));
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(lvl_valid || eoi_valid));
  // R7
  rsn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsn_valid |-> $past(rej_valid));
  // R13
  launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch));
  // R12
  src_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> dlv_src[SRC_W-1:IDX_W] == CTRL_ID);
endmodule

// File: tb/isc_bank_tb_top.sv
module isc_bank_tb_top;
  localparam int NSRC = 16, CTRL_W = 4, PRIO_W = 8, SRV_W = 4;
  localparam logic [CTRL_W-1:0] CID = 4'h3;
  localparam int IDX_W = 4;
  localparam int ITEM_W = CTRL_W + IDX_W + PRIO_W + SRV_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lvl_valid = 0, lvl_value = 0, cfg_valid = 0, cfg_lsi = 0;
  logic eoi_valid = 0, rej_valid = 0, resend_req = 0, dlv_ready = 1;
  logic [IDX_W-1:0] lvl_idx = 0, cfg_idx = 0, eoi_idx = 0, rej_idx = 0;
  logic [1:0] cfg_op = 2'b11;
  logic [SRV_W-1:0] cfg_server = 0;
  logic [PRIO_W-1:0] cfg_prio = 0;
  logic dlv_valid, rsn_valid, err_pulse;
  logic [CTRL_W+IDX_W-1:0] dlv_src;
  logic [PRIO_W-1:0] dlv_prio;
  logic [SRV_W-1:0] dlv_server;
  logic [CTRL_W-1:0] rsn_ctrl;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [ITEM_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  isc_bank #(.NSRC(NSRC), .CTRL_W(CTRL_W), .CTRL_ID(CID), .PRIO_W(PRIO_W), .SRV_W(SRV_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lvl_valid(lvl_valid), .lvl_idx(lvl_idx), .lvl_value(lvl_value),
    .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_idx(cfg_idx),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_lsi(cfg_lsi),
    .eoi_valid(eoi_valid), .eoi_idx(eoi_idx),
    .rej_valid(rej_valid), .rej_idx(rej_idx), .resend_req(resend_req),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_src(dlv_src),
    .dlv_prio(dlv_prio), .dlv_server(dlv_server),
    .rsn_valid(rsn_valid), .rsn_ctrl(rsn_ctrl), .err_pulse(err_pulse)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input int idx, input int pr, input int sv);
    exp_q.push_back({CID, IDX_W'(idx), PRIO_W'(pr), SRV_W'(sv)});
  endtask

  // monitor: compares every accepted request against the scoreboard
  always begin
    @(negedge clk); #1;
    if (rst_n && dlv_valid && dlv_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R13 unexpected request", {dlv_src, dlv_prio, dlv_server}, 0);
      else begin
        logic [ITEM_W-1:0] e;
        e = exp_q.pop_front();
        chk({dlv_src, dlv_prio, dlv_server} == e, "R12 request content/order",
            {dlv_src, dlv_prio, dlv_server}, e);
      end
    end
  end

  task automatic cfg(input logic [1:0] op, input int idx, input int sv, input int pr, input bit lsi);
    @(negedge clk);
    cfg_valid = 1; cfg_op = op; cfg_idx = IDX_W'(idx);
    cfg_server = SRV_W'(sv); cfg_prio = PRIO_W'(pr); cfg_lsi = lsi;
    @(negedge clk);
    cfg_valid = 0; cfg_op = 2'b11;
  endtask

  task automatic lvl(input int idx, input bit v, input bit exp_err);
    @(negedge clk);
    lvl_valid = 1; lvl_idx = IDX_W'(idx); lvl_value = v;
    @(negedge clk);
    lvl_valid = 0; #1;
    chk(err_pulse == exp_err, "R10 error pulse on level", err_pulse, exp_err);
  endtask

  task automatic eoi(input int idx, input bit exp_err);
    @(negedge clk);
    eoi_valid = 1; eoi_idx = IDX_W'(idx);
    @(negedge clk);
    eoi_valid = 0; #1;
    chk(err_pulse == exp_err, "R10 error pulse on eoi", err_pulse, exp_err);
  endtask

  task automatic rej(input int idx);
    @(negedge clk);
    rej_valid = 1; rej_idx = IDX_W'(idx);
    @(negedge clk);
    rej_valid = 0; #1;
    chk(rsn_valid && rsn_ctrl == CID, "R7 refusal notice", {rsn_valid, rsn_ctrl}, {1'b1, CID});
  endtask

  task automatic settle(input string req);
    repeat (8) @(negedge clk);
    #1;
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!dlv_valid && !err_pulse && !rsn_valid, "R1 reset outputs idle",
        {dlv_valid, err_pulse, rsn_valid}, 0);
    // R10: unconfigured source
    lvl(0, 1, 1);
    eoi(0, 1);
    settle("R10 unconfigured source silent");
    // R3 / R12: level-sensitive source 2
    cfg(2'b00, 2, 3, 5, 1);
    expect_item(2, 5, 3);
    lvl(2, 1, 0);
    settle("R3 level rise delivers");
    lvl(2, 0, 0);
    settle("R3 level fall silent");
    // R8
    eoi(2, 0);
    settle("R8 eoi not asserted silent");
    expect_item(2, 5, 3);
    lvl(2, 1, 0);
    settle("R3 level rise again");
    expect_item(2, 5, 3);
    eoi(2, 0);
    settle("R8 eoi asserted redelivers");
    lvl(2, 0, 0);
    // R5 / R2 / R6
    cfg(2'b10, 2, 0, 0, 0);
    lvl(2, 1, 0);
    settle("R2 masked attempt held");
    cfg(2'b11, 2, 0, 0, 0);
    settle("R6 no-op code silent");
    expect_item(2, 5, 3);
    cfg(2'b01, 2, 0, 0, 0);
    settle("R6 enable releases held with saved priority");
    lvl(2, 0, 0);
    // R4: set with 0xFF keeps masked, set with real priority releases
    cfg(2'b00, 5, 1, 8'hFF, 0);
    lvl(5, 1, 0);
    settle("R4 masked set holds");
    expect_item(5, 9, 1);
    cfg(2'b00, 5, 1, 9, 0);
    settle("R4 set releases held mark");
    expect_item(5, 9, 1);
    lvl(5, 1, 0);
    settle("R3 edge source delivers");
    // R7 / R9: refusals and stalled resend walk
    cfg(2'b00, 1, 2, 4, 0);
    cfg(2'b00, 6, 7, 2, 0);
    cfg(2'b00, 4, 0, 8'hFF, 0);
    rej(6);
    rej(4);
    rej(1);
    settle("R7 refusal alone delivers nothing");
    @(negedge clk);
    dlv_ready = 0;
    expect_item(1, 4, 2);
    expect_item(6, 2, 7);
    resend_req = 1;
    @(negedge clk);
    resend_req = 0;
    repeat (6) @(negedge clk);
    #1;
    chk(dlv_valid && dlv_src == {CID, 4'd1}, "R11 stalled request held", dlv_src, {CID, 4'd1});
    dlv_ready = 1;
    settle("R9 walk ascending and masked source held");
    // R13: lowest index wins
    @(negedge clk);
    dlv_ready = 0;
    expect_item(6, 2, 7);
    expect_item(1, 4, 2);
    expect_item(5, 9, 1);
    lvl(6, 1, 0);
    lvl(5, 1, 0);
    lvl(1, 1, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(dlv_valid && dlv_src == {CID, 4'd6} && dlv_prio == 8'd2, "R11 fields stable under stall",
        {dlv_src, dlv_prio}, {CID, 4'd6, 8'd2});
    dlv_ready = 1;
    settle("R13 lowest index first");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule